// File: doc/BRIEF.md
# Host Register Bank with State-Gated Writes

This block holds the configuration and status registers of a network controller core, reached over a simple host bus whose data width is set at build time to 8 or 16 bits. It drives the stored configuration values to the core. It returns register contents to the host one cycle after a read strobe. It also enforces the core's access rules. Only the mode register may be changed while the core is active. Every other read/write register takes writes only while the core reports idle. Bits not defined in a register are never stored and always read as zero.

With an 8-bit bus, every byte of a 16-bit register has its own byte address, and the even address selects the low byte. With a 16-bit bus, a register is reached at its even address as a whole word. An odd address is then illegal. A write that is refused for either reason leaves every register untouched and raises a one-cycle error pulse. One status register mirrors an input from the core, sampled on every clock, and writes to it have no effect.

Register map (word index = byte address / 2): 0 mode (valid bits 3:0, reset 0x0001), 1 transmit config (bits 8:0, reset 0x0000), 2 receive config (bits 7:0, reset 0x0004), 3 gap config (bits 4:0, reset 0x000C), 4 length limit (bits 13:0, reset 0x05EE), 5 status, read-only (bits 7:0, reset 0x0000).

Top module: `hif_regfile`

## Requirements
- R1: When reset is released, every register holds its defined reset value: mode 0x0001, transmit 0x0000, receive 0x0004, gap 0x000C, length 0x05EE, status 0x0000.
- R2: With a 16-bit bus, a write to an even address of a register (byte address 2*index) replaces the whole word, and a read there returns the whole word.
- R3: With a 16-bit bus, a write to an odd address changes no register and sets wr_err in the following cycle; a read of an odd address returns 0.
- R4: With an 8-bit bus, byte address 2*index+0 reaches bits 7:0 and 2*index+1 reaches bits 15:8 of register index; a byte write changes only that byte, and odd addresses are legal.
- R5: Undefined bits of a register ignore written values and read back as 0.
- R6: While core_idle is 0, a write to any read/write register other than mode leaves it unchanged and sets wr_err in the following cycle.
- R7: The mode register accepts writes whatever the value of core_idle, with no error.
- R8: The status register returns core_stat bits 7:0 as sampled on the clock edge before the read is registered; writes to it are ignored and raise no error.
- R9: hst_rdata is updated on the clock edge where hst_rd is sampled high and otherwise holds its value; an address beyond index 5 reads as 0, and a write to it changes nothing and raises no error.
- R10: wr_err is high for exactly one cycle per refused write and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hst_addr | input | ADDR_W | Host byte address |
| hst_wdata | input | HOST_W | Host write data |
| hst_wr | input | 1 | Write strobe, one cycle per access |
| hst_rd | input | 1 | Read strobe, one cycle per access |
| hst_rdata | output | HOST_W | Read data, valid the cycle after hst_rd |
| core_idle | input | 1 | Core reports the idle state |
| core_stat | input | 16 | Live status from the core |
| cfg_mode | output | 16 | Mode register contents |
| cfg_tx | output | 16 | Transmit configuration |
| cfg_rx | output | 16 | Receive configuration |
| cfg_gap | output | 16 | Gap configuration |
| cfg_len | output | 16 | Length limit |
| wr_err | output | 1 | One-cycle pulse after a refused write |

## Verification
The hardest case to reach is a write refused while the core is busy, hitting one byte of a register on the 8-bit build, next to a mode write that must still succeed in the same busy window. The bench lowers core_idle between accesses and first writes a byte of a gated register. It then writes the mode register, reads both back, and checks that the error pulse appears for the first write only. Both bus widths are built side by side, so the same refusals are seen through word and byte addressing.

// File: rtl/hif_pkg.sv
package hif_pkg;
  localparam int NREG  = 6;
  localparam int IDX_W = 3;

  localparam int IDX_MODE = 0;
  localparam int IDX_TX   = 1;
  localparam int IDX_RX   = 2;
  localparam int IDX_GAP  = 3;
  localparam int IDX_LEN  = 4;
  localparam int IDX_STAT = 5;

  typedef logic [15:0] word_t;

  localparam word_t REG_MASK [NREG] = '{16'h000F, 16'h01FF, 16'h00FF,
                                        16'h001F, 16'h3FFF, 16'h00FF};
  localparam word_t REG_POR  [NREG] = '{16'h0001, 16'h0000, 16'h0004,
                                        16'h000C, 16'h05EE, 16'h0000};
  localparam bit    REG_RO   [NREG] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [1:0]       be;
    logic             odd;
  } dec_t;
endpackage

// File: rtl/hif_decode.sv
module hif_decode
  import hif_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int WI_W = ADDR_W - 1;

  logic [WI_W-1:0] word_idx;

  assign word_idx = addr[ADDR_W-1:1];

  generate
    if (HOST_W == 8) begin : g_byte
      always_comb begin
        dec.hit = (word_idx < WI_W'(NREG));
        dec.idx = word_idx[IDX_W-1:0];
        dec.be  = addr[0] ? 2'b10 : 2'b01;
        dec.odd = 1'b0;
      end
    end else begin : g_word
      always_comb begin
        dec.hit = (word_idx < WI_W'(NREG));
        dec.idx = word_idx[IDX_W-1:0];
        dec.be  = 2'b11;
        dec.odd = addr[0];
      end
    end
  endgenerate
endmodule

// File: rtl/hif_wgate.sv
module hif_wgate
  import hif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  dec_t dec,
  input  logic core_idle,
  output logic we,
  output logic err
);
  logic is_mode;
  logic is_ro;
  logic state_ok;
  logic target_rw;

  always_comb begin
    is_mode   = (dec.idx == IDX_W'(IDX_MODE));
    is_ro     = (dec.idx == IDX_W'(IDX_STAT));
    state_ok  = core_idle || is_mode;
    target_rw = dec.hit && !dec.odd && !is_ro;
    we        = wr && target_rw && state_ok;
    err       = wr && (dec.odd || (dec.hit && !is_ro && !state_ok));
  end

  // R3 / R6: a refused write never reaches a register
  a_r6_err_excludes_we: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !we);

  // R7: the mode register is never refused for state reasons
  a_r7_mode_not_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec.hit && !dec.odd && is_mode) |-> (we && !err));
endmodule

// File: rtl/hif_field.sv
module hif_field
  import hif_pkg::*;
#(
  parameter word_t POR  = 16'h0000,
  parameter word_t MASK = 16'hFFFF,
  parameter bit    RO   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] be,
  input  word_t      wdata,
  input  word_t      stat,
  output word_t      q
);
  word_t q_nxt;

  generate
    if (RO) begin : g_ro
      always_comb q_nxt = stat & MASK;
    end else begin : g_rw
      always_comb begin
        q_nxt = q;
        if (we && be[0]) q_nxt[7:0]  = wdata[7:0];
        if (we && be[1]) q_nxt[15:8] = wdata[15:8];
        q_nxt = q_nxt & MASK;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= POR;
    else        q <= q_nxt;
  end

  // R5: undefined bits never hold a one
  a_r5_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~MASK) == 16'h0000);

  // R6: without a write enable a read/write register keeps its value
  a_r6_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
    (!RO && !we) |=> $stable(q));
endmodule

// File: rtl/hif_regfile.sv
module hif_regfile
  import hif_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [HOST_W-1:0] hst_wdata,
  input  logic              hst_wr,
  input  logic              hst_rd,
  output logic [HOST_W-1:0] hst_rdata,
  input  logic              core_idle,
  input  logic [15:0]       core_stat,
  output logic [15:0]       cfg_mode,
  output logic [15:0]       cfg_tx,
  output logic [15:0]       cfg_rx,
  output logic [15:0]       cfg_gap,
  output logic [15:0]       cfg_len,
  output logic              wr_err
);
  dec_t              dec;
  word_t             wdata16;
  logic              we;
  logic              err;
  word_t             q_arr [NREG];
  word_t             rd_word;
  logic [HOST_W-1:0] rd_lane;
  logic [HOST_W-1:0] rdata_nxt;
  logic              err_nxt;

  hif_decode #(.HOST_W(HOST_W), .ADDR_W(ADDR_W)) u_dec (
    .addr (hst_addr),
    .dec  (dec)
  );

  hif_wgate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (hst_wr),
    .dec       (dec),
    .core_idle (core_idle),
    .we        (we),
    .err       (err)
  );

  generate
    if (HOST_W == 8) begin : g_wd8
      assign wdata16 = {hst_wdata, hst_wdata};
    end else begin : g_wd16
      assign wdata16 = hst_wdata[15:0];
    end
  endgenerate

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic we_i;
      assign we_i = we && (dec.idx == IDX_W'(i));
      hif_field #(.POR(REG_POR[i]), .MASK(REG_MASK[i]), .RO(REG_RO[i])) u_fld (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_i),
        .be    (dec.be),
        .wdata (wdata16),
        .stat  (core_stat),
        .q     (q_arr[i])
      );
    end
  endgenerate

  assign cfg_mode = q_arr[IDX_MODE];
  assign cfg_tx   = q_arr[IDX_TX];
  assign cfg_rx   = q_arr[IDX_RX];
  assign cfg_gap  = q_arr[IDX_GAP];
  assign cfg_len  = q_arr[IDX_LEN];

  always_comb begin
    rd_word = 16'h0000;
    for (int i = 0; i < NREG; i++) begin
      if (dec.hit && !dec.odd && (dec.idx == IDX_W'(i))) rd_word = q_arr[i];
    end
  end

  generate
    if (HOST_W == 8) begin : g_rl8
      assign rd_lane = hst_addr[0] ? rd_word[15:8] : rd_word[7:0];
    end else begin : g_rl16
      assign rd_lane = rd_word;
    end
  endgenerate

  always_comb begin
    rdata_nxt = hst_rd ? rd_lane : hst_rdata;
    err_nxt   = err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hst_rdata <= '0;
      wr_err    <= 1'b0;
    end else begin
      hst_rdata <= rdata_nxt;
      wr_err    <= err_nxt;
    end
  end

  // R10: an error pulse only follows a write strobe
  a_r10_err_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(hst_wr));

  // R9: read data holds while no read is strobed
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_rd |=> $stable(hst_rdata));

  // R6: busy core keeps every gated register unchanged
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !core_idle |=> $stable({cfg_tx, cfg_rx, cfg_gap, cfg_len}));

  // R5: outputs carry no undefined bits
  a_r5_cfg_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_mode & ~REG_MASK[IDX_MODE]) == 16'h0) && ((cfg_len & ~REG_MASK[IDX_LEN]) == 16'h0));

  generate
    if (HOST_W == 16) begin : g_a16
      // R7: a word write to mode lands regardless of core state
      a_r7_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && !hst_addr[0] && (hst_addr[ADDR_W-1:1] == '0)) |=>
          (cfg_mode == ($past(wdata16) & REG_MASK[IDX_MODE])));
      // R3: odd address writes are always refused
      a_r3_odd_err: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_addr[0]) |=> wr_err);
    end
  endgenerate
endmodule

// File: tb/tb_hif_regfile.sv
module tb_hif_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_idle = 1'b1;
  logic [15:0] core_stat = 16'h0000;

  logic [7:0]  a16 = '0, a8 = '0;
  logic [15:0] d16 = '0;
  logic [7:0]  d8 = '0;
  logic        wr16 = 1'b0, rd16 = 1'b0, wr8 = 1'b0, rd8 = 1'b0;
  logic [15:0] rdata16;
  logic [7:0]  rdata8;
  logic [15:0] m16, t16, r16, g16, l16, m8, t8, r8, g8, l8;
  logic        err16, err8;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  bit done   = 1'b0;

  typedef struct {
    int          sel;
    int          req;
    logic [15:0] exp;
    int          cyc;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  hif_regfile #(.HOST_W(16), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .hst_addr(a16), .hst_wdata(d16), .hst_wr(wr16),
    .hst_rd(rd16), .hst_rdata(rdata16), .core_idle(core_idle), .core_stat(core_stat),
    .cfg_mode(m16), .cfg_tx(t16), .cfg_rx(r16), .cfg_gap(g16), .cfg_len(l16),
    .wr_err(err16));

  hif_regfile #(.HOST_W(8), .ADDR_W(8)) dut_b8 (
    .clk(clk), .rst_n(rst_n), .hst_addr(a8), .hst_wdata(d8), .hst_wr(wr8),
    .hst_rd(rd8), .hst_rdata(rdata8), .core_idle(core_idle), .core_stat(core_stat),
    .cfg_mode(m8), .cfg_tx(t8), .cfg_rx(r8), .cfg_gap(g8), .cfg_len(l8),
    .wr_err(err8));

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after each read strobe
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc == cycle - 1) begin
      item_t it;
      it = sbq.pop_front();
      if (it.sel == 0) chk(it.req, rdata16, it.exp, "read16");
      else             chk(it.req, {8'h00, rdata8}, it.exp, "read8");
    end
  end

  task automatic rd_reg(input int sel, input logic [7:0] a, input logic [15:0] exp,
                        input int req);
    item_t it;
    @(negedge clk);
    if (sel == 0) begin a16 = a; rd16 = 1'b1; end
    else          begin a8 = a;  rd8  = 1'b1; end
    it.sel = sel; it.req = req; it.exp = exp; it.cyc = cycle;
    sbq.push_back(it);
    @(negedge clk);
    rd16 = 1'b0; rd8 = 1'b0;
  endtask

  task automatic wr_reg(input int sel, input logic [7:0] a, input logic [15:0] d,
                        input bit exp_err, input int req);
    @(negedge clk);
    if (sel == 0) begin a16 = a; d16 = d;      wr16 = 1'b1; end
    else          begin a8 = a;  d8 = d[7:0];  wr8  = 1'b1; end
    @(negedge clk);
    wr16 = 1'b0; wr8 = 1'b0;
    chk(req, {15'h0, (sel == 0) ? err16 : err8}, {15'h0, exp_err}, "error pulse");
    @(negedge clk);
    // R10: pulse lasts one cycle
    chk(10, {15'h0, (sel == 0) ? err16 : err8}, 16'h0, "error pulse width");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values at the configuration outputs and through reads
    chk(1, m16, 16'h0001, "mode reset");
    chk(1, g16, 16'h000C, "gap reset");
    chk(1, l8,  16'h05EE, "len reset b8");
    chk(10, {15'h0, err16}, 16'h0, "no error at reset");
    rd_reg(0, 8'h00, 16'h0001, 1);
    rd_reg(0, 8'h04, 16'h0004, 1);
    rd_reg(0, 8'h08, 16'h05EE, 1);
    rd_reg(0, 8'h0A, 16'h0000, 1);

    // R2 / R5: word writes with masking
    wr_reg(0, 8'h02, 16'hABCD, 1'b0, 2);
    rd_reg(0, 8'h02, 16'h01CD, 2);
    chk(5, t16, 16'h01CD, "tx reserved bits");
    wr_reg(0, 8'h00, 16'hFFFF, 1'b0, 7);
    rd_reg(0, 8'h00, 16'h000F, 5);
    wr_reg(0, 8'h08, 16'hFFFF, 1'b0, 2);
    rd_reg(0, 8'h08, 16'h3FFF, 5);

    // R3: odd address on the word bus
    wr_reg(0, 8'h03, 16'h1234, 1'b1, 3);
    rd_reg(0, 8'h02, 16'h01CD, 3);
    rd_reg(0, 8'h03, 16'h0000, 3);

    // R6 / R7: busy core
    core_idle = 1'b0;
    wr_reg(0, 8'h02, 16'h0055, 1'b1, 6);
    rd_reg(0, 8'h02, 16'h01CD, 6);
    wr_reg(0, 8'h06, 16'h0003, 1'b1, 6);
    chk(6, g16, 16'h000C, "gap kept while busy");
    wr_reg(0, 8'h00, 16'h0003, 1'b0, 7);
    rd_reg(0, 8'h00, 16'h0003, 7);
    core_idle = 1'b1;
    wr_reg(0, 8'h06, 16'h0013, 1'b0, 6);
    chk(6, g16, 16'h0013, "gap written when idle");

    // R8: status mirrors core input, writes ignored
    core_stat = 16'hA5C3;
    repeat (2) @(negedge clk);
    rd_reg(0, 8'h0A, 16'h00C3, 8);
    wr_reg(0, 8'h0A, 16'hFFFF, 1'b0, 8);
    rd_reg(0, 8'h0A, 16'h00C3, 8);
    core_stat = 16'h003C;
    repeat (2) @(negedge clk);
    rd_reg(0, 8'h0A, 16'h003C, 8);

    // R9: unmapped address and read hold
    wr_reg(0, 8'h20, 16'h7777, 1'b0, 9);
    rd_reg(0, 8'h20, 16'h0000, 9);
    repeat (3) @(negedge clk);
    chk(9, rdata16, 16'h0000, "read data held");

    // R4: byte bus addressing
    rd_reg(1, 8'h08, 16'h00EE, 4);
    rd_reg(1, 8'h09, 16'h0005, 4);
    wr_reg(1, 8'h09, 16'h0012, 1'b0, 4);
    rd_reg(1, 8'h08, 16'h00EE, 4);
    rd_reg(1, 8'h09, 16'h0012, 4);
    wr_reg(1, 8'h08, 16'h0034, 1'b0, 4);
    chk(4, l8, 16'h1234, "len after byte writes");
    wr_reg(1, 8'h03, 16'h00FF, 1'b0, 5);
    rd_reg(1, 8'h03, 16'h0001, 5);
    rd_reg(1, 8'h0A, 16'h003C, 8);
    rd_reg(1, 8'h0B, 16'h0000, 8);

    // R6 / R7 on the byte bus
    core_idle = 1'b0;
    wr_reg(1, 8'h06, 16'h001F, 1'b1, 6);
    wr_reg(1, 8'h00, 16'h0006, 1'b0, 7);
    rd_reg(1, 8'h06, 16'h000C, 6);
    rd_reg(1, 8'h00, 16'h0006, 7);
    core_idle = 1'b1;

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 reads left unchecked: actual %0d expected 0", sbq.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule